// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block is one channel of a debug breakpoint unit. It watches every bus cycle on a monitor port and raises a break interrupt when the cycle matches a condition that software has programmed. A condition has two parts. The first is a full 32-bit break address. The second is four 2-bit selectors that qualify the cycle: which master drives it (CPU or peripheral), what kind of access it is (instruction fetch or data), its direction (read or write), and its operand size.

Software programs the channel through a small word-wide register port at four offsets:

| Offset | Contents |
|--------|----------|
| 0 | Upper address half |
| 1 | Lower address half |
| 2 | Cycle selector register |
| 3 | Status register |

The monitor side supplies a valid strobe with the address and attributes of each cycle. The block registers the comparison result. The interrupt is therefore a pulse one clock after the matching cycle, and a sticky status flag records that a break has occurred.

The pulse is produced by a two-state machine:

- `ST_QUIET`: no interrupt.
- `ST_FIRE`: interrupt asserted.

Its transitions are:

- QUIET→FIRE on a match.
- FIRE→FIRE on a further match in the next cycle.
- FIRE→QUIET when no match is seen.
- QUIET→QUIET when idle.

Top module: `brk_chan_cmp`

## Requirements
- R1: After reset every register reads zero, `brk_irq` and `brk_flag` are 0, and no cycle can raise a break until software programs the selectors.
- R2: Offset 0 reads and writes break address bits 31:16 in data bits 15:0. Offset 1 does the same for address bits 15:0.
- R3: Offset 2 holds the selectors in fixed bit positions:

  | Bits | Selector |
  |------|----------|
  | 7:6 | Master |
  | 5:4 | Access kind |
  | 3:2 | Direction |
  | 1:0 | Size |

  Bits 15:8 of offset 2 always read zero and ignore writes.
- R4: Master selector: 00 never breaks, 01 accepts CPU cycles (`mon_periph`=0), 10 accepts peripheral cycles (`mon_periph`=1), 11 accepts both.
- R5: Access kind selector: 00 never breaks, 01 accepts fetch cycles (`mon_data`=0), 10 accepts data cycles (`mon_data`=1), 11 accepts both.
- R6: Direction selector: 00 never breaks, 01 accepts reads (`mon_write`=0), 10 accepts writes (`mon_write`=1), 11 accepts both.
- R7: Size selector values:
  - 00 makes size irrelevant.
  - 01 requires a byte access.
  - 10 requires a word access.
  - 11 requires a longword access.

  The monitor reports size as 00 byte, 01 word, 10 longword. A monitor size of 11 matches only when the size selector is 00.
- R8: A break requires `mon_addr` to equal all 32 bits of the break address.
- R9: A cycle is evaluated only while `mon_valid` is 1. `brk_irq` is 1 in exactly the clock that follows each matching cycle and 0 otherwise.
- R10: Bit 0 of offset 3 is a sticky flag. It is set in the same clock that `brk_irq` rises and is cleared by writing 1 to bit 0. Writing 0 has no effect, and a set in the same clock as a clear wins.
- R11: A register write applies to cycles from the next clock on. A cycle presented in the same clock as the write is judged by the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| mon_valid | input | 1 | Monitored bus cycle is valid |
| mon_addr | input | 32 | Monitored cycle address |
| mon_periph | input | 1 | 1 = peripheral cycle, 0 = CPU cycle |
| mon_data | input | 1 | 1 = data access, 0 = instruction fetch |
| mon_write | input | 1 | 1 = write, 0 = read |
| mon_size | input | 2 | 00 byte, 01 word, 10 longword |
| brk_irq | output | 1 | One-clock break interrupt pulse |
| brk_flag | output | 1 | Sticky break status flag |

## Verification
A corrupted selector or address register shows at once on `reg_rdata` for its offset. It also shows on `brk_irq` one clock after the first monitored cycle whose outcome it changes. A machine stuck in `ST_FIRE` shows as `brk_irq` staying high for a second clock after a lone match. A lost or spurious flag update is visible on `brk_flag` and on offset 3 in the very next clock. The reference model predicts all three outputs every clock, so any of these faults is caught within one cycle of the stimulus that exposes it.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        RA_ADDR_HI = 2'd0,
        RA_ADDR_LO = 2'd1,
        RA_CYCLE   = 2'd2,
        RA_STATUS  = 2'd3
    } brk_reg_e;

    typedef struct packed {
        logic [1:0] master;
        logic [1:0] kind;
        logic [1:0] dir;
        logic [1:0] size;
    } brk_sel_t;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_FIRE  = 1'b1
    } brk_state_e;

    localparam int unsigned SEL_W = $bits(brk_sel_t);

    // Monitor size code -> size selector code; reserved code maps to 00
    function automatic logic [1:0] size_to_sel(input logic [1:0] code);
        logic [1:0] r;
        unique case (code)
            2'b00:   r = 2'b01;
            2'b01:   r = 2'b10;
            2'b10:   r = 2'b11;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic [ADDR_W-1:0] bk_addr,
    output brk_sel_t          sel,
    output logic [DATA_W-1:0] rdata,
    output logic              flag_clr
);

    logic [DATA_W-1:0] half_q [2];

    // Two address halves: index 1 is the upper half, index 0 the lower
    for (genvar g = 0; g < 2; g++) begin : g_half
        localparam logic [1:0] HALF_OFS = (g == 1) ? RA_ADDR_HI : RA_ADDR_LO;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                half_q[g] <= '0;
            end else if (we && addr == HALF_OFS) begin
                half_q[g] <= wdata;
            end
        end
        assign bk_addr[g*DATA_W +: DATA_W] = half_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (we && addr == RA_CYCLE) begin
            sel <= brk_sel_t'(wdata[SEL_W-1:0]);
        end
    end

    always_comb begin
        unique case (brk_reg_e'(addr))
            RA_ADDR_HI: rdata = half_q[1];
            RA_ADDR_LO: rdata = half_q[0];
            RA_CYCLE:   rdata = DATA_W'(sel);
            RA_STATUS:  rdata = DATA_W'(flag);
            default:    rdata = '0;
        endcase
    end

    assign flag_clr = we && (addr == RA_STATUS) && wdata[0];

endmodule

// File: rtl/brk_match.sv
module brk_match
    import brk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              periph,
    input  logic              data,
    input  logic              write,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] bk_addr,
    input  brk_sel_t          sel,
    output logic              hit
);

    logic addr_ok;
    logic master_ok;
    logic kind_ok;
    logic dir_ok;
    logic size_ok;

    // Each two-bit selector: bit 0 accepts the first kind, bit 1 the second
    always_comb begin
        addr_ok   = (cyc_addr == bk_addr);
        master_ok = periph ? sel.master[1] : sel.master[0];
        kind_ok   = data   ? sel.kind[1]   : sel.kind[0];
        dir_ok    = write  ? sel.dir[1]    : sel.dir[0];
        size_ok   = (sel.size == 2'b00) || (sel.size == size_to_sel(size));
        hit       = valid && addr_ok && master_ok && kind_ok && dir_ok && size_ok;
    end

endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    output logic irq,
    output logic flag
);

    brk_state_e state_q;
    brk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_QUIET: state_d = hit ? ST_FIRE : ST_QUIET;
            ST_FIRE:  state_d = hit ? ST_FIRE : ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FIRE: irq = 1'b1;
            default: irq = 1'b0;
        endcase
    end

    // Sticky flag: a new match wins over a clear in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/brk_chan_cmp.sv
module brk_chan_cmp
    import brk_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mon_valid,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              mon_periph,
    input  logic              mon_data,
    input  logic              mon_write,
    input  logic [1:0]        mon_size,
    output logic              brk_irq,
    output logic              brk_flag
);

    logic [ADDR_W-1:0] bk_addr;
    brk_sel_t          cyc_sel;
    logic              flag_clr;
    logic              hit;

    brk_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .flag     (brk_flag),
        .bk_addr  (bk_addr),
        .sel      (cyc_sel),
        .rdata    (reg_rdata),
        .flag_clr (flag_clr)
    );

    brk_match #(.ADDR_W(ADDR_W)) u_match (
        .valid    (mon_valid),
        .cyc_addr (mon_addr),
        .periph   (mon_periph),
        .data     (mon_data),
        .write    (mon_write),
        .size     (mon_size),
        .bk_addr  (bk_addr),
        .sel      (cyc_sel),
        .hit      (hit)
    );

    brk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flag_clr (flag_clr),
        .irq      (brk_irq),
        .flag     (brk_flag)
    );

endmodule

// File: rtl/brk_chan_cmp_chk.sv
module brk_chan_cmp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hit,
    input logic [7:0]  cyc_bits,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        mon_valid,
    input logic        brk_irq,
    input logic        brk_flag
);

    AST_HIT_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> brk_irq); // R9

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !brk_irq); // R9

    AST_NO_HIT_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_valid |-> !hit); // R9

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> brk_flag); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !(reg_we && reg_addr == 2'd3 && reg_wdata[0])) |=> brk_flag); // R10

    AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_bits[7:6] == 2'b00) |-> !hit); // R4

    AST_KIND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_bits[5:4] == 2'b00) |-> !hit); // R5

    AST_DIR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_bits[3:2] == 2'b00) |-> !hit); // R6

    AST_CYCLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> (reg_rdata[15:8] == 8'h00)); // R3

endmodule

bind brk_chan_cmp brk_chan_cmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .cyc_bits  (cyc_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mon_valid (mon_valid),
    .brk_irq   (brk_irq),
    .brk_flag  (brk_flag)
);

// File: tb/brk_chan_cmp_tb.sv
`timescale 1ns/1ps
module brk_chan_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mon_valid = 1'b0;
    logic [31:0] mon_addr = '0;
    logic        mon_periph = 1'b0;
    logic        mon_data = 1'b0;
    logic        mon_write = 1'b0;
    logic [1:0]  mon_size = 2'b00;
    logic        brk_irq;
    logic        brk_flag;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    brk_chan_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
        .mon_addr(mon_addr), .mon_periph(mon_periph), .mon_data(mon_data),
        .mon_write(mon_write), .mon_size(mon_size), .brk_irq(brk_irq),
        .brk_flag(brk_flag)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_hi, m_lo;
    logic [7:0]  m_cyc;
    logic        m_irq, m_flag;

    function automatic bit model_hit();
        int sz;
        if (!mon_valid) return 0;
        if (mon_addr != {m_hi, m_lo}) return 0;
        if (!m_cyc[6 + (mon_periph ? 1 : 0)]) return 0;
        if (!m_cyc[4 + (mon_data ? 1 : 0)]) return 0;
        if (!m_cyc[2 + (mon_write ? 1 : 0)]) return 0;
        sz = int'(m_cyc[1:0]);
        if (sz == 0) return 1;
        if (mon_size == 2'b11) return 0;
        return (sz == int'(mon_size) + 1);
    endfunction

    function automatic logic [15:0] model_rdata();
        case (reg_addr)
            2'd0:    return m_hi;
            2'd1:    return m_lo;
            2'd2:    return {8'h00, m_cyc};
            default: return {15'h0, m_flag};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hi <= '0; m_lo <= '0; m_cyc <= '0; m_irq <= 1'b0; m_flag <= 1'b0;
        end else begin
            m_irq <= model_hit();
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_hi  <= reg_wdata;
                    2'd1: m_lo  <= reg_wdata;
                    2'd2: m_cyc <= reg_wdata[7:0];
                    default: ;
                endcase
            end
            if (model_hit()) m_flag <= 1'b1;
            else if (reg_we && reg_addr == 2'd3 && reg_wdata[0]) m_flag <= 1'b0;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "model irq",   32'(brk_irq),   32'(m_irq));
            check(cur_req, "model flag",  32'(brk_flag),  32'(m_flag));
            check(cur_req, "model rdata", 32'(reg_rdata), 32'(model_rdata()));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_check(string req, input logic [1:0] a, input logic [15:0] exp);
        @(posedge clk); #1;
        reg_addr = a;
        #2;
        check(req, "readback", 32'(reg_rdata), 32'(exp));
    endtask

    task automatic cyc(string req, input logic [31:0] a, input logic per,
                       input logic dat, input logic wrt, input logic [1:0] sz,
                       input logic vld, input logic exp);
        @(posedge clk); #1;
        mon_valid = vld; mon_addr = a; mon_periph = per;
        mon_data = dat; mon_write = wrt; mon_size = sz;
        @(posedge clk); #1;
        mon_valid = 1'b0;
        check(req, "irq after cycle", 32'(brk_irq), 32'(exp));
    endtask

    localparam logic [31:0] BA = 32'hA5C3_1E70;

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        check("R1", "irq", 32'(brk_irq), 0);
        check("R1", "flag", 32'(brk_flag), 0);
        for (int i = 0; i < 4; i++) rd_check("R1", 2'(i), 16'h0000);
        cyc("R1", 32'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);

        // R2: address halves
        cur_req = "R2";
        wr(2'd0, BA[31:16]);
        wr(2'd1, BA[15:0]);
        rd_check("R2", 2'd0, BA[31:16]);
        rd_check("R2", 2'd1, BA[15:0]);

        // R3: cycle register layout
        cur_req = "R3";
        wr(2'd2, 16'hFFFF);
        rd_check("R3", 2'd2, 16'h00FF);
        wr(2'd2, 16'h5A9C);
        rd_check("R3", 2'd2, 16'h009C);
        wr(2'd3, 16'h0001);

        // R4: master selector (kind=11, dir=11, size=00)
        cur_req = "R4";
        wr(2'd2, 16'h007C);
        cyc("R4", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);
        cyc("R4", BA, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        wr(2'd2, 16'h00BC);
        cyc("R4", BA, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1);
        cyc("R4", BA, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0);
        wr(2'd2, 16'h00FC);
        cyc("R4", BA, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1);
        wr(2'd2, 16'h003C);
        cyc("R4", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);

        // R5: access kind
        cur_req = "R5";
        wr(2'd2, 16'h00DC);
        cyc("R5", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);
        cyc("R5", BA, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);
        wr(2'd2, 16'h00EC);
        cyc("R5", BA, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
        cyc("R5", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        wr(2'd2, 16'h00CC);
        cyc("R5", BA, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0);

        // R6: direction
        cur_req = "R6";
        wr(2'd2, 16'h00F4);
        cyc("R6", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);
        cyc("R6", BA, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
        wr(2'd2, 16'h00F8);
        cyc("R6", BA, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1);
        cyc("R6", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        wr(2'd2, 16'h00F0);
        cyc("R6", BA, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);

        // R7: size
        cur_req = "R7";
        wr(2'd2, 16'h00FD);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0);
        wr(2'd2, 16'h00FE);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0);
        wr(2'd2, 16'h00FF);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0);
        wr(2'd2, 16'h00FC);
        cyc("R7", BA, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1);

        // R8: full address compare
        cur_req = "R8";
        cyc("R8", BA ^ 32'h8000_0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        cyc("R8", BA ^ 32'h0000_0001, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        cyc("R8", BA ^ 32'h0001_0000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        cyc("R8", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1);

        // R9: valid gating and pulse width
        cur_req = "R9";
        cyc("R9", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
        @(posedge clk); #1;
        mon_valid = 1'b1; mon_addr = BA;
        @(posedge clk); #1;
        check("R9", "first of two", 32'(brk_irq), 1);
        @(posedge clk); #1;
        mon_valid = 1'b0;
        check("R9", "second of two", 32'(brk_irq), 1);
        @(posedge clk); #1;
        check("R9", "pulse ends", 32'(brk_irq), 0);

        // R10: sticky flag
        cur_req = "R10";
        check("R10", "flag set", 32'(brk_flag), 1);
        wr(2'd3, 16'hFFFE);
        check("R10", "write 0 keeps flag", 32'(brk_flag), 1);
        wr(2'd3, 16'h0001);
        check("R10", "write 1 clears", 32'(brk_flag), 0);
        @(posedge clk); #1;
        mon_valid = 1'b1; mon_addr = BA;
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0001;
        @(posedge clk); #1;
        mon_valid = 1'b0; reg_we = 1'b0;
        check("R10", "set wins over clear", 32'(brk_flag), 1);
        wr(2'd3, 16'h0001);

        // R11: write timing relative to a cycle in the same clock
        cur_req = "R11";
        @(posedge clk); #1;
        mon_valid = 1'b1; mon_addr = BA;
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0000;
        @(posedge clk); #1;
        mon_valid = 1'b0; reg_we = 1'b0;
        check("R11", "old settings used", 32'(brk_irq), 1);
        cyc("R11", BA, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule